// File: doc/BRIEF.md
# Flash Command Register Controller

This block models the command logic that sits in front of a parallel NOR flash array. The bus it sees is asynchronous: an active-low chip select, write strobe and read strobe, plus address and data. The block brings the chip select and write strobe into the system clock and finds the strobe edges there. It then decodes one- and two-write command sequences. A separate input says whether the programming high voltage is present. Commands are accepted only while it is present. When it is absent, the block falls back to plain array reads.

The decoded command sets the source of each bus read. A read can return the array word at the bus address, one of two identifier bytes, or the array word at a stored erase-check address or program address. A completed erase sequence or program sequence raises a one-cycle start strobe, with the operation address and data alongside it. The array is outside the block: the block drives an array address and receives the array word back.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, and at any time the high-voltage input is low, bus writes are ignored: no strobe fires, and reads return the array word at the bus address.
- R2: A bus write starts when the synchronized write strobe falls while chip select is low. The address is taken at that falling edge. The data is taken at the following rising edge, which completes the write.
- R3: Writing 0x00 selects array read: reads return the array word at the bus address.
- R4: After writing 0x90, a read at address 0 returns the manufacturer byte (default 0x89) and a read at address 1 returns the device byte (default 0xB4).
- R5: Writing 0x20 and then 0x20 again produces one `erase_go` pulse. The pulse carries the second write's address and data, and the block then returns to array read.
- R6: Writing 0xA0 stores that write's address. Later reads drive the stored address to the array and return its word, whatever the bus address is.
- R7: Writing 0x40 and then any byte produces one `prog_go` pulse carrying the second write's address and data. That address is kept as the program address.
- R8: Writing 0xC0 makes reads return the array word at the kept program address.
- R9: Writing 0xFF twice returns the block to array read with no strobe, ready for a new command.
- R10: If the second write of an erase pair does not repeat 0x20, no strobe fires and the block returns to array read.
- R11: While a two-write sequence is half done, reads return the array word at the bus address. `erase_go` and `prog_go` are each one cycle wide.
- R12: `bus_rdata` is zero whenever chip select or read strobe is high.
- R13: Dropping the high-voltage input clears any selected mode. After it returns, reads come from the array until a new command is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hv_ok | input | 1 | Programming high voltage present |
| bus_ce_n | input | 1 | Bus chip select, active low, asynchronous |
| bus_we_n | input | 1 | Bus write strobe, active low, asynchronous |
| bus_oe_n | input | 1 | Bus read strobe, active low |
| bus_addr | input | AW | Bus address |
| bus_wdata | input | DW | Bus write data |
| bus_rdata | output | DW | Bus read data |
| arr_addr | output | AW | Address driven to the array |
| arr_rdata | input | DW | Word returned by the array |
| erase_go | output | 1 | One-cycle erase start strobe |
| prog_go | output | 1 | One-cycle program start strobe |
| op_addr | output | AW | Address of the started operation |
| op_data | output | DW | Data of the started operation |

## Verification
A strobe edge on the bus reaches the decoder two clock edges later, after the two synchronizer flops. The decoder acts on the third edge, so a mode change or a start strobe appears three edges after the bus edge. The bench therefore holds every bus level for five cycles, which covers that delay for both the falling-edge address capture and the rising-edge data capture. Read data is combinational from the registered mode and the bus inputs, so each read is sampled one falling clock edge after its address is driven. Start strobes are counted by a monitor on the falling clock edge, so no pulse is missed whenever it lands.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   localparam logic [7:0] CMD_ARRAY    = 8'h00;
   localparam logic [7:0] CMD_IDENT    = 8'h90;
   localparam logic [7:0] CMD_ERASE    = 8'h20;
   localparam logic [7:0] CMD_ERASE_CK = 8'hA0;
   localparam logic [7:0] CMD_PROG     = 8'h40;
   localparam logic [7:0] CMD_PROG_CK  = 8'hC0;
   localparam logic [7:0] CMD_RESET    = 8'hFF;

   typedef enum logic [2:0] {
      MD_ARRAY,
      MD_IDENT,
      MD_ERASE_ARM,
      MD_ERASE_CHK,
      MD_PROG_ARM,
      MD_PROG_CHK,
      MD_RESET_ARM
   } fmode_e;

endpackage

// File: rtl/flash_bus_sync.sv
module flash_bus_sync #(
   parameter int          W      = 2,
   parameter int          STAGES = 2,
   parameter logic [W-1:0] IDLE  = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_in,
   output logic [W-1:0] sync_out,
   output logic [W-1:0] fell,
   output logic [W-1:0] rose
);

   localparam int LAST = STAGES;

   if (STAGES < 2) begin : g_bad_stages
      $error("flash_bus_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [LAST+1];

   for (genvar g = 0; g <= LAST; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= IDLE;
            else        chain[g] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) chain[g] <= IDLE;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign sync_out = chain[LAST-1];
   assign fell     = chain[LAST] & ~chain[LAST-1];
   assign rose     = ~chain[LAST] & chain[LAST-1];

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
   import flash_cmd_pkg::*;
#(
   parameter int AW = 17,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hv_ok,
   input  logic          we_fall,
   input  logic          we_rise,
   input  logic          ce_low,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output fmode_e        mode,
   output logic [AW-1:0] ev_addr,
   output logic [AW-1:0] pa_addr,
   output logic          erase_go,
   output logic          prog_go,
   output logic [AW-1:0] op_addr,
   output logic [DW-1:0] op_data
);

   if (DW < 8) begin : g_bad_dw
      $error("flash_cmd_fsm: DW must be at least 8");
   end

   logic          wr_open;
   logic [AW-1:0] lat_addr;

   function automatic logic is_cmd(input logic [DW-1:0] d, input logic [7:0] c);
      return d == DW'(c);
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode     <= MD_ARRAY;
         wr_open  <= 1'b0;
         lat_addr <= '0;
         ev_addr  <= '0;
         pa_addr  <= '0;
         erase_go <= 1'b0;
         prog_go  <= 1'b0;
         op_addr  <= '0;
         op_data  <= '0;
      end else begin
         erase_go <= 1'b0;
         prog_go  <= 1'b0;
         if (we_fall && ce_low) begin
            wr_open  <= 1'b1;
            lat_addr <= bus_addr;
         end
         if (!hv_ok) begin
            mode    <= MD_ARRAY;
            wr_open <= 1'b0;
         end else if (we_rise && wr_open) begin
            wr_open <= 1'b0;
            case (mode)
               MD_ERASE_ARM: begin
                  if (is_cmd(bus_wdata, CMD_ERASE)) begin
                     erase_go <= 1'b1;
                     op_addr  <= lat_addr;
                     op_data  <= bus_wdata;
                  end
                  mode <= MD_ARRAY;
               end
               MD_PROG_ARM: begin
                  prog_go <= 1'b1;
                  op_addr <= lat_addr;
                  op_data <= bus_wdata;
                  pa_addr <= lat_addr;
                  mode    <= MD_ARRAY;
               end
               MD_RESET_ARM: mode <= MD_ARRAY;
               default: begin
                  if      (is_cmd(bus_wdata, CMD_IDENT))    mode <= MD_IDENT;
                  else if (is_cmd(bus_wdata, CMD_ERASE))    mode <= MD_ERASE_ARM;
                  else if (is_cmd(bus_wdata, CMD_PROG))     mode <= MD_PROG_ARM;
                  else if (is_cmd(bus_wdata, CMD_PROG_CK))  mode <= MD_PROG_CHK;
                  else if (is_cmd(bus_wdata, CMD_RESET))    mode <= MD_RESET_ARM;
                  else if (is_cmd(bus_wdata, CMD_ERASE_CK)) begin
                     mode    <= MD_ERASE_CHK;
                     ev_addr <= lat_addr;
                  end else mode <= MD_ARRAY;
               end
            endcase
         end
      end
   end

   p_erase_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      erase_go |=> !erase_go);
   p_prog_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      prog_go |=> !prog_go);
   p_hv_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !hv_ok |=> (!erase_go && !prog_go));
   p_erase_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
      erase_go |-> $past(mode) == MD_ERASE_ARM);
   p_prog_arm_r7: assert property (@(posedge clk) disable iff (!rst_n)
      prog_go |-> $past(mode) == MD_PROG_ARM);
   p_pa_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MD_PROG_CHK) |=> $stable(pa_addr));

endmodule

// File: rtl/flash_read_sel.sv
module flash_read_sel
   import flash_cmd_pkg::*;
#(
   parameter int          AW       = 17,
   parameter int          DW       = 8,
   parameter logic [DW-1:0] MFR_CODE = DW'(8'h89),
   parameter logic [DW-1:0] DEV_CODE = DW'(8'hB4)
) (
   input  fmode_e        mode,
   input  logic          ce_n,
   input  logic          oe_n,
   input  logic [AW-1:0] bus_addr,
   input  logic [AW-1:0] ev_addr,
   input  logic [AW-1:0] pa_addr,
   input  logic [DW-1:0] arr_rdata,
   output logic [AW-1:0] arr_addr,
   output logic [DW-1:0] bus_rdata
);

   if (AW < 1) begin : g_bad_aw
      $error("flash_read_sel: AW must be at least 1");
   end

   always_comb begin
      case (mode)
         MD_ERASE_CHK: arr_addr = ev_addr;
         MD_PROG_CHK:  arr_addr = pa_addr;
         default:      arr_addr = bus_addr;
      endcase
   end

   always_comb begin
      if (ce_n || oe_n)                    bus_rdata = '0;
      else if (mode != MD_IDENT)           bus_rdata = arr_rdata;
      else if (bus_addr == AW'(0))         bus_rdata = MFR_CODE;
      else if (bus_addr == AW'(1))         bus_rdata = DEV_CODE;
      else                                 bus_rdata = '0;
   end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
   import flash_cmd_pkg::*;
#(
   parameter int            AW          = 17,
   parameter int            DW          = 8,
   parameter int            SYNC_STAGES = 2,
   parameter logic [DW-1:0] MFR_CODE    = DW'(8'h89),
   parameter logic [DW-1:0] DEV_CODE    = DW'(8'hB4)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hv_ok,
   input  logic          bus_ce_n,
   input  logic          bus_we_n,
   input  logic          bus_oe_n,
   input  logic [AW-1:0] bus_addr,
   input  logic [DW-1:0] bus_wdata,
   output logic [DW-1:0] bus_rdata,
   output logic [AW-1:0] arr_addr,
   input  logic [DW-1:0] arr_rdata,
   output logic          erase_go,
   output logic          prog_go,
   output logic [AW-1:0] op_addr,
   output logic [DW-1:0] op_data
);

   localparam int STROBES = 2;

   logic [STROBES-1:0] strb_sync, strb_fell, strb_rose;
   fmode_e             mode;
   logic [AW-1:0]      ev_addr, pa_addr;

   flash_bus_sync #(.W(STROBES), .STAGES(SYNC_STAGES), .IDLE('1)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in({bus_ce_n, bus_we_n}),
      .sync_out(strb_sync), .fell(strb_fell), .rose(strb_rose));

   flash_cmd_fsm #(.AW(AW), .DW(DW)) u_fsm (
      .clk(clk), .rst_n(rst_n), .hv_ok(hv_ok),
      .we_fall(strb_fell[0]), .we_rise(strb_rose[0]), .ce_low(~strb_sync[1]),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .mode(mode),
      .ev_addr(ev_addr), .pa_addr(pa_addr), .erase_go(erase_go),
      .prog_go(prog_go), .op_addr(op_addr), .op_data(op_data));

   flash_read_sel #(.AW(AW), .DW(DW), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_rsel (
      .mode(mode), .ce_n(bus_ce_n), .oe_n(bus_oe_n), .bus_addr(bus_addr),
      .ev_addr(ev_addr), .pa_addr(pa_addr), .arr_rdata(arr_rdata),
      .arr_addr(arr_addr), .bus_rdata(bus_rdata));

   p_no_dual_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(erase_go && prog_go));
   p_strobe_needs_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_go || prog_go) |-> $past(strb_rose[0]));

endmodule

// File: tb/flash_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_tb_top;

   localparam int AW = 17;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          hv_ok = 1'b1;
   logic          bus_ce_n = 1'b1, bus_we_n = 1'b1, bus_oe_n = 1'b1;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata, arr_rdata, op_data;
   logic [AW-1:0] arr_addr, op_addr;
   logic          erase_go, prog_go;

   int checks = 0, fails = 0;
   int e_cnt = 0, p_cnt = 0;
   logic [AW-1:0] e_addr = '0, p_addr = '0;
   logic [DW-1:0] p_data = '0;

   always #2 clk = ~clk;

   function automatic logic [7:0] model(input logic [AW-1:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   assign arr_rdata = model(arr_addr);

   flash_cmd_ctrl #(.AW(AW), .DW(DW)) dut_i (
      .clk(clk), .rst_n(rst_n), .hv_ok(hv_ok), .bus_ce_n(bus_ce_n),
      .bus_we_n(bus_we_n), .bus_oe_n(bus_oe_n), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .arr_addr(arr_addr),
      .arr_rdata(arr_rdata), .erase_go(erase_go), .prog_go(prog_go),
      .op_addr(op_addr), .op_data(op_data));

   always @(negedge clk) begin
      if (erase_go) begin e_cnt++; e_addr = op_addr; end
      if (prog_go)  begin p_cnt++; p_addr = op_addr; p_data = op_data; end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   // address a1 at the falling strobe edge, data d1 then d2 before the rise
   task automatic bus_write(input logic [AW-1:0] a1, input logic [AW-1:0] a2,
                            input logic [7:0] d1, input logic [7:0] d2);
      @(negedge clk);
      bus_ce_n = 1'b0; bus_addr = a1; bus_wdata = d1;
      @(negedge clk);
      bus_we_n = 1'b0;
      repeat (5) @(negedge clk);
      bus_addr = a2; bus_wdata = d2;
      repeat (2) @(negedge clk);
      bus_we_n = 1'b1;
      repeat (5) @(negedge clk);
      bus_ce_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      bus_write(a, a, d, d);
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
      @(negedge clk);
      bus_addr = a; bus_ce_n = 1'b0; bus_oe_n = 1'b0;
      @(negedge clk);
      v = bus_rdata;
      bus_ce_n = 1'b1; bus_oe_n = 1'b1;
   endtask

   typedef struct packed {
      logic [1:0]    op;   // 0 write, 1 read expecting array word at x, 2 read expecting d
      logic [AW-1:0] a;
      logic [AW-1:0] x;
      logic [7:0]    d;
      logic [3:0]    rq;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t VECS [NV] = '{
      '{2'd1, 17'h00123, 17'h00123, 8'h00, 4'd1},  // R1 array read after reset
      '{2'd0, 17'h00000, 17'h00000, 8'h90, 4'd4},
      '{2'd2, 17'h00000, 17'h00000, 8'h89, 4'd4},  // R4 manufacturer byte
      '{2'd2, 17'h00001, 17'h00000, 8'hB4, 4'd4},  // R4 device byte
      '{2'd0, 17'h00000, 17'h00000, 8'h00, 4'd3},
      '{2'd1, 17'h00456, 17'h00456, 8'h00, 4'd3},  // R3 back to array
      '{2'd0, 17'h1ABCD, 17'h00000, 8'hA0, 4'd6},
      '{2'd1, 17'h00001, 17'h1ABCD, 8'h00, 4'd6},  // R6 stored address used
      '{2'd1, 17'h00099, 17'h1ABCD, 8'h00, 4'd6},
      '{2'd0, 17'h00000, 17'h00000, 8'h40, 4'd7},
      '{2'd0, 17'h0F0F0, 17'h00000, 8'h3C, 4'd7},
      '{2'd0, 17'h00000, 17'h00000, 8'hC0, 4'd8},
      '{2'd1, 17'h00007, 17'h0F0F0, 8'h00, 4'd8},  // R8 kept program address
      '{2'd0, 17'h00000, 17'h00000, 8'h20, 4'd5},
      '{2'd1, 17'h00222, 17'h00222, 8'h00, 4'd11}, // R11 read mid-sequence
      '{2'd0, 17'h12345, 17'h00000, 8'h20, 4'd5},
      '{2'd1, 17'h00333, 17'h00333, 8'h00, 4'd5},  // R5 array after erase
      '{2'd0, 17'h00000, 17'h00000, 8'hFF, 4'd9},
      '{2'd1, 17'h00444, 17'h00444, 8'h00, 4'd11},
      '{2'd0, 17'h00000, 17'h00000, 8'hFF, 4'd9},
      '{2'd1, 17'h00555, 17'h00555, 8'h00, 4'd9},  // R9 reset pair
      '{2'd0, 17'h00000, 17'h00000, 8'h20, 4'd10},
      '{2'd0, 17'h00000, 17'h00000, 8'h21, 4'd10},
      '{2'd1, 17'h00666, 17'h00666, 8'h00, 4'd10}  // R10 dropped pair
   };

   initial begin
      repeat (50000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 reset erase_go", erase_go, 0);
      check("R1 reset prog_go", prog_go, 0);

      for (int i = 0; i < NV; i++) begin
         if (VECS[i].op == 2'd0) wr(VECS[i].a, VECS[i].d);
         else begin
            rd(VECS[i].a, v);
            checks++;
            if (v !== (VECS[i].op == 2'd1 ? model(VECS[i].x) : VECS[i].d)) begin
               fails++;
               $display("FAIL R%0d vector %0d actual=%h expected=%h", VECS[i].rq, i, v,
                        VECS[i].op == 2'd1 ? model(VECS[i].x) : VECS[i].d);
            end
         end
      end

      check("R5 erase pulse count", e_cnt, 1);
      check("R5 erase address", e_addr, 17'h12345);
      check("R10 no extra erase", e_cnt, 1);
      check("R7 program pulse count", p_cnt, 1);
      check("R7 program address", p_addr, 17'h0F0F0);
      check("R7 program data", p_data, 8'h3C);

      // R2: address from falling edge, data from rising edge
      wr(17'h0, 8'h40);
      bus_write(17'h00AAA, 17'h1F00F, 8'h11, 8'h77);
      check("R2 program count", p_cnt, 2);
      check("R2 address at fall", p_addr, 17'h00AAA);
      check("R2 data at rise", p_data, 8'h77);

      // R12: read strobe high gives zero
      @(negedge clk);
      bus_addr = 17'h00123; bus_ce_n = 1'b0; bus_oe_n = 1'b1;
      @(negedge clk);
      check("R12 idle read data", bus_rdata, 0);
      bus_ce_n = 1'b1;

      // R1: no high voltage, writes ignored
      hv_ok = 1'b0;
      wr(17'h0, 8'h20);
      wr(17'h0, 8'h20);
      check("R1 erase blocked", e_cnt, 1);
      wr(17'h0, 8'h90);
      rd(17'h0, v);
      check("R1 ident blocked", v, model(17'h0));

      // R13: high voltage drop clears mode
      hv_ok = 1'b1;
      wr(17'h0, 8'h90);
      rd(17'h0, v);
      check("R13 ident before drop", v, 8'h89);
      @(negedge clk); hv_ok = 1'b0;
      repeat (3) @(negedge clk); hv_ok = 1'b1;
      rd(17'h0, v);
      check("R13 array after drop", v, model(17'h0));

      finish_run();
   end

endmodule